// File: doc/BRIEF.md
# Truth-Table ALU with Flag-Composed Comparator

This block is the combinational execute stage of a small register-register processor. It receives a 16-bit instruction word and the values of two register operands, D (the destination, also the left-hand operand) and S (the source, the right-hand operand). It returns the value to write back to D and a write-enable. The top nibble of the instruction selects one of three instruction classes. Any other top nibble leaves the write-enable low.

The bitwise class has no fixed opcodes. A 4-bit truth table taken from the instruction is applied to every bit position. At position i, the pair {D[i], S[i]} indexes the table. The arithmetic class offers eight operations: add, subtract, three shifts, two rotates and negate. Its S operand is either the register value or a 4-bit immediate taken from the instruction.

The compare class builds its test from separate flag bits: equality, greater-than, signed and invert. It writes 1 when the test holds and 0 when it does not. The word width is a parameter with a default of 64 bits. It must be a power of two and at least 16.

Top module: `tt_exec_unit`

## Requirements
- R1: With insn[15:12] = 4'h1 (bitwise class), each result bit i equals bit {D[i],S[i]} of the table M = insn[11:8], with D[i] as the more significant index bit; wr_en is 1.
- R2: The bitwise table values give the expected functions: M=0 gives all zeros, M=15 gives all ones, M=8 gives AND, M=14 gives OR, M=6 gives XOR, M=12 returns D and M=10 returns S.
- R3: With insn[15:12] = 4'h2 (arithmetic class), insn[10:8] picks the operation. Code 0 is D+S, code 1 is D-S and code 7 is -S. All of them wrap modulo 2^WIDTH, and wr_en is 1.
- R4: Arithmetic codes 2 (shift left, zero fill), 3 (logical shift right) and 4 (arithmetic shift right, filling with D's top bit) shift by S modulo WIDTH. An amount of zero returns D unchanged.
- R5: Arithmetic codes 5 (rotate left) and 6 (rotate right) rotate D by S modulo WIDTH.
- R6: When insn[11] is 1 in the arithmetic class, the S operand is insn[7:4] zero-extended, and the S register input is ignored.
- R7: With insn[15:12] = 4'h3 (compare class), the test is (insn[8] and D==S) or (insn[9] and D>S). The greater test is unsigned when insn[10] is 0.
- R8: In the compare class, insn[10] = 1 makes the greater test two's-complement signed.
- R9: In the compare class, insn[11] inverts the test. The result is exactly 1 for a true test and 0 for a false one, and wr_en is 1.
- R10: For any other top nibble, wr_en is 0 and the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 16 | Instruction word |
| opnd_d | input | WIDTH | Value of the D register (left operand) |
| opnd_s | input | WIDTH | Value of the S register (right operand) |
| result | output | WIDTH | Value to write back to D |
| wr_en | output | 1 | High when the result should be written to D |

## Verification
The assertions assume that every input carries a known 0/1 value whenever the outputs are evaluated, and that WIDTH is a power of two, so that taking the low bits of S is the same as reducing the amount modulo WIDTH. The bench drives every input from its declaration onward and changes the inputs only at a rising clock edge. It reads the outputs at the following falling edge, after the combinational logic has settled. Shift amounts of WIDTH and above are applied on purpose, so the modulo rule is exercised rather than assumed.

// File: rtl/tt_exec_pkg.sv
package tt_exec_pkg;

    localparam logic [3:0] CLS_BITWISE = 4'h1;
    localparam logic [3:0] CLS_ARITH   = 4'h2;
    localparam logic [3:0] CLS_CMP     = 4'h3;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_SHL = 3'd2,
        OP_SHR = 3'd3,
        OP_ASR = 3'd4,
        OP_ROL = 3'd5,
        OP_ROR = 3'd6,
        OP_NEG = 3'd7
    } arith_op_e;

    // compare flags as they sit in insn[11:8]
    typedef struct packed {
        logic invert;
        logic is_signed;
        logic want_gt;
        logic want_eq;
    } cmp_flags_t;

    function automatic logic lut_bit(input logic [3:0] tbl, input logic dbit, input logic sbit);
        return tbl[{dbit, sbit}];
    endfunction

endpackage

// File: rtl/tt_bitwise_unit.sv
module tt_bitwise_unit
    import tt_exec_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [3:0]       table_m,
    input  logic [WIDTH-1:0] opnd_d,
    input  logic [WIDTH-1:0] opnd_s,
    output logic [WIDTH-1:0] bit_res
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign bit_res[i] = lut_bit(table_m, opnd_d[i], opnd_s[i]);
    end

    always_comb begin
        if (table_m == 4'd0)
            assert_tt_false_R2: assert (bit_res == '0) else $error("table 0 not zero");
        if (table_m == 4'd15)
            assert_tt_true_R2: assert (bit_res == '1) else $error("table 15 not ones");
        if (table_m == 4'd12)
            assert_tt_keep_d_R2: assert (bit_res == opnd_d) else $error("table 12 not D");
    end

endmodule

// File: rtl/tt_arith_unit.sv
module tt_arith_unit
    import tt_exec_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  arith_op_e        op,
    input  logic             use_imm,
    input  logic [3:0]       imm_field,
    input  logic [WIDTH-1:0] opnd_d,
    input  logic [WIDTH-1:0] opnd_s,
    output logic [WIDTH-1:0] arith_res
);

    localparam int SHW = $clog2(WIDTH);

    logic [WIDTH-1:0]   s_eff;
    logic [SHW-1:0]     amt;
    logic [2*WIDTH-1:0] rot_l;
    logic [2*WIDTH-1:0] rot_r;

    assign s_eff = use_imm ? {{(WIDTH-4){1'b0}}, imm_field} : opnd_s;
    assign amt   = s_eff[SHW-1:0];
    assign rot_l = {opnd_d, opnd_d} << amt;
    assign rot_r = {opnd_d, opnd_d} >> amt;

    always_comb begin
        unique case (op)
            OP_ADD:  arith_res = opnd_d + s_eff;
            OP_SUB:  arith_res = opnd_d - s_eff;
            OP_SHL:  arith_res = opnd_d << amt;
            OP_SHR:  arith_res = opnd_d >> amt;
            OP_ASR:  arith_res = $unsigned($signed(opnd_d) >>> amt);
            OP_ROL:  arith_res = rot_l[2*WIDTH-1:WIDTH];
            OP_ROR:  arith_res = rot_r[WIDTH-1:0];
            OP_NEG:  arith_res = '0 - s_eff;
            default: arith_res = '0;
        endcase
    end

    always_comb begin
        if (op inside {OP_SHL, OP_SHR, OP_ASR, OP_ROL, OP_ROR} && amt == '0)
            assert_zero_shift_R4: assert (arith_res == opnd_d) else $error("zero shift changed D");
        if (op == OP_ADD && use_imm && imm_field == 4'd0)
            assert_imm_zero_add_R6: assert (arith_res == opnd_d) else $error("imm 0 add changed D");
    end

endmodule

// File: rtl/tt_compare_unit.sv
module tt_compare_unit
    import tt_exec_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  cmp_flags_t       flags,
    input  logic [WIDTH-1:0] opnd_d,
    input  logic [WIDTH-1:0] opnd_s,
    output logic [WIDTH-1:0] cmp_res
);

    logic is_eq;
    logic is_gt;
    logic raw_test;
    logic verdict;

    assign is_eq    = (opnd_d == opnd_s);
    assign is_gt    = flags.is_signed ? ($signed(opnd_d) > $signed(opnd_s)) : (opnd_d > opnd_s);
    assign raw_test = (flags.want_eq & is_eq) | (flags.want_gt & is_gt);
    assign verdict  = raw_test ^ flags.invert;
    assign cmp_res  = {{(WIDTH-1){1'b0}}, verdict};

    always_comb begin
        if (!flags.want_eq && !flags.want_gt)
            assert_const_test_R9: assert (cmp_res[0] == flags.invert) else $error("flagless test wrong");
        if (flags.want_eq && opnd_d == opnd_s)
            assert_eq_hit_R7: assert (cmp_res[0] == !flags.invert) else $error("equal operands missed");
    end

endmodule

// File: rtl/tt_exec_unit.sv
module tt_exec_unit
    import tt_exec_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [15:0]      insn,
    input  logic [WIDTH-1:0] opnd_d,
    input  logic [WIDTH-1:0] opnd_s,
    output logic [WIDTH-1:0] result,
    output logic             wr_en
);

    logic [3:0]       cls;
    logic [WIDTH-1:0] bit_res;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] cmp_res;
    logic             unused_regnum;

    assign cls           = insn[15:12];
    assign unused_regnum = ^insn[3:0];

    tt_bitwise_unit #(.WIDTH(WIDTH)) u_bitwise (
        .table_m (insn[11:8]),
        .opnd_d  (opnd_d),
        .opnd_s  (opnd_s),
        .bit_res (bit_res)
    );

    tt_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .op        (arith_op_e'(insn[10:8])),
        .use_imm   (insn[11]),
        .imm_field (insn[7:4]),
        .opnd_d    (opnd_d),
        .opnd_s    (opnd_s),
        .arith_res (arith_res)
    );

    tt_compare_unit #(.WIDTH(WIDTH)) u_compare (
        .flags   (cmp_flags_t'(insn[11:8])),
        .opnd_d  (opnd_d),
        .opnd_s  (opnd_s),
        .cmp_res (cmp_res)
    );

    always_comb begin
        wr_en  = 1'b1;
        result = '0;
        case (cls)
            CLS_BITWISE: result = bit_res;
            CLS_ARITH:   result = arith_res;
            CLS_CMP:     result = cmp_res;
            default:     wr_en  = 1'b0;
        endcase
    end

    always_comb begin
        if (!wr_en)
            assert_idle_zero_R10: assert (result == '0) else $error("idle result nonzero");
        if (cls == CLS_CMP)
            assert_cmp_boolean_R9: assert (result[WIDTH-1:1] == '0) else $error("compare result not 0/1");
    end

endmodule

// File: tb/tt_exec_unit_bench.sv
module tt_exec_unit_bench;

    localparam int W = 64;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic         clk = 1'b0;
    logic [15:0]  insn = 16'h0000;
    logic [W-1:0] opnd_d = '0;
    logic [W-1:0] opnd_s = '0;
    logic [W-1:0] result;
    logic         wr_en;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tt_exec_unit #(.WIDTH(W)) u_tt_exec_unit (
        .insn   (insn),
        .opnd_d (opnd_d),
        .opnd_s (opnd_s),
        .result (result),
        .wr_en  (wr_en)
    );

    task automatic apply(input logic [15:0] i, input logic [W-1:0] d, input logic [W-1:0] s);
        @(posedge clk);
        insn   = i;
        opnd_d = d;
        opnd_s = s;
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [15:0] i, input logic [W-1:0] d,
                          input logic [W-1:0] s, input logic [W-1:0] exp, input logic exp_we);
        apply(i, d, s);
        chk(tag, result, exp);
        chk({tag, " wr_en"}, {{(W-1){1'b0}}, wr_en}, {{(W-1){1'b0}}, exp_we});
    endtask

    task automatic t_idle_start();
        run_op("R10 start idle", 16'h0000, '0, '0, '0, 1'b0);
    endtask

    task automatic t_bitwise();
        logic [W-1:0] d = 64'hF0F0;
        logic [W-1:0] s = 64'hFF00;
        run_op("R2 AND",  16'h1821, d, s, 64'hF000, 1'b1);
        run_op("R2 OR",   16'h1E21, d, s, 64'hFFF0, 1'b1);
        run_op("R2 XOR",  16'h1621, d, s, 64'h0FF0, 1'b1);
        run_op("R1 tbl2", 16'h1221, d, s, 64'h0F00, 1'b1);
        run_op("R1 tbl4", 16'h1421, d, s, 64'h00F0, 1'b1);
        run_op("R2 false",16'h1021, d, s, '0, 1'b1);
        run_op("R2 true", 16'h1F21, d, s, ONES, 1'b1);
        run_op("R2 keepD",16'h1C21, d, s, d, 1'b1);
        run_op("R2 copyS",16'h1A21, d, s, s, 1'b1);
    endtask

    task automatic t_arith_basic();
        run_op("R3 add wrap", 16'h2000, ONES, 64'd1, '0, 1'b1);
        run_op("R3 sub",      16'h2100, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1);
        run_op("R3 neg",      16'h2700, 64'd100, 64'd5, 64'hFFFF_FFFF_FFFF_FFFB, 1'b1);
    endtask

    task automatic t_shifts();
        run_op("R4 shl mod",  16'h2200, 64'd1, 64'd68, 64'd16, 1'b1);
        run_op("R4 shr",      16'h2300, 64'h8000_0000_0000_0000, 64'd63, 64'd1, 1'b1);
        run_op("R4 asr",      16'h2400, 64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000, 1'b1);
        run_op("R4 asr pos",  16'h2400, 64'h0000_0000_0000_0100, 64'd4, 64'h10, 1'b1);
        run_op("R4 zero amt", 16'h2200, 64'h1234, 64'd64, 64'h1234, 1'b1);
        run_op("R5 rol",      16'h2500, 64'h8000_0000_0000_0001, 64'd1, 64'd3, 1'b1);
        run_op("R5 ror",      16'h2600, 64'h8000_0000_0000_0001, 64'd1, 64'hC000_0000_0000_0000, 1'b1);
    endtask

    task automatic t_immediate();
        run_op("R6 imm add", 16'h2870, 64'd10, 64'd999, 64'd17, 1'b1);
        run_op("R6 imm ror", 16'h2E40, 64'd1, 64'd0, 64'h1000_0000_0000_0000, 1'b1);
        run_op("R6 imm neg", 16'h2F20, 64'd9, 64'd77, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1);
    endtask

    task automatic t_compare();
        run_op("R7 eq hit",       16'h3100, 64'd7, 64'd7, 64'd1, 1'b1);
        run_op("R7 eq miss",      16'h3100, 64'd7, 64'd8, 64'd0, 1'b1);
        run_op("R7 above",        16'h3200, ONES, 64'd1, 64'd1, 1'b1);
        run_op("R8 greater",      16'h3600, ONES, 64'd1, 64'd0, 1'b1);
        run_op("R8 greater pos",  16'h3600, 64'd1, ONES, 64'd1, 1'b1);
        run_op("R9 below/equal",  16'h3A00, ONES, 64'd1, 64'd0, 1'b1);
        run_op("R9 less",         16'h3E00, ONES, 64'd1, 64'd1, 1'b1);
        run_op("R9 false",        16'h3000, 64'd4, 64'd4, 64'd0, 1'b1);
        run_op("R9 true",         16'h3800, 64'd4, 64'd5, 64'd1, 1'b1);
    endtask

    task automatic t_other_classes();
        run_op("R10 nibble4", 16'h4123, ONES, ONES, '0, 1'b0);
        run_op("R10 nibble0", 16'h0FFF, ONES, ONES, '0, 1'b0);
        run_op("R10 nibbleF", 16'hF000, ONES, ONES, '0, 1'b0);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_idle_start();
        t_bitwise();
        t_arith_basic();
        t_shifts();
        t_immediate();
        t_compare();
        t_other_classes();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule